// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block is a bank of four independent event counters for a cache controller. Each counter has its own configuration slot holding an event-select code and a clear-on-read flag. Every cycle, each counter adds one when the event it selects is present. The events arrive as a vector of single-cycle pulses, and bit N of that vector is the pulse for code N. Code 0 is special: it counts every clock cycle.

A simple register port lets software write a counter's configuration and read its value. A read returns the counter's value one cycle later on a registered data output. If the counter's clear-on-read flag is set, the read also zeroes that counter. Writing a configuration only changes which event is counted and whether reads clear the count; the accumulated count is kept. Nothing forces a counter to be configured before use: from reset every counter counts cycles.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous reset, every count is zero, every counter selects code 0 with clear-on-read off, `rd_valid` is 0 and `rd_data` is 0.
- R2: A counter that selects code 0 increments on every clock cycle out of reset, whatever the value of `evt_pulse[0]`.
- R3: A counter that selects code N, with 1 ≤ N ≤ 53, increments in exactly those cycles in which `evt_pulse[N]` is 1.
- R4: A counter that selects a code from 54 to 63 never increments.
- R5: A read with `rd_en`=1 and index `rd_idx` in cycle t gives `rd_valid`=1 in cycle t+1. In that cycle `rd_data` holds the count accumulated over cycles before t, so the read cycle's own event is excluded. `rd_valid` is 0 in a cycle that follows no read.
- R6: When the read counter has clear-on-read set, its count after the read edge is 0. If its selected event also occurs in the read cycle, the count is 1 instead.
- R7: When the read counter has clear-on-read off, the read leaves its count unchanged.
- R8: A configuration write (`cfg_wr`=1, `cfg_idx`, `cfg_code`, `cfg_clr_on_rd`) leaves the count untouched. In the write cycle the counter still uses its old selection, and the new one applies from the next cycle.
- R9: Counts wrap modulo 2^CTR_W (2^64 by default).
- R10: Counters are independent. A write or a clearing read aimed at one counter does not change the count or configuration of any other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_EVT (54) | Event pulses, bit N for code N |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (2) | Counter addressed by the write |
| cfg_code | input | CODE_W (6) | Event code to select |
| cfg_clr_on_rd | input | 1 | New clear-on-read flag |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W (2) | Counter addressed by the read |
| rd_data | output | CTR_W (64) | Registered read value |
| rd_valid | output | 1 | High the cycle after a read |

## Verification
Two situations are hard to reach from the ports. The first is wrap-around, which a 64-bit counter never reaches in a test. The bench therefore builds the bank with a 10-bit counter width and runs the cycle-counting code past 1024. The second is a clearing read that lands in the same cycle as the selected event. Here the stimulus drives the selected pulse high exactly in the read cycle and then reads again to see the count of 1. Every code from 0 to 63 is swept across the four counters using pseudo-random event patterns.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int CODE_W    = 6;
  localparam int EVT_COUNT = 54;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              clr_on_rd;
  } ctr_cfg_t;
endpackage

// File: rtl/pcb_cfg_slot.sv
module pcb_cfg_slot
  import pcb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  ctr_cfg_t wr_cfg,
  output ctr_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= wr_cfg;
  end

  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/pcb_event_mux.sv
module pcb_event_mux #(
  parameter int NUM_EVT = pcb_pkg::EVT_COUNT,
  parameter int CODE_W  = pcb_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [CODE_W-1:0]  code,
  output logic               hit
);
  localparam int SPAN = 1 << CODE_W;

  logic [SPAN-1:0] evt_ext;

  generate
    if (SPAN > NUM_EVT) begin : g_pad
      assign evt_ext = {{(SPAN-NUM_EVT){1'b0}}, evt};
    end else begin : g_trim
      assign evt_ext = evt[SPAN-1:0];
    end
  endgenerate

  always_comb begin
    if (code == '0) hit = 1'b1;
    else            hit = evt_ext[code];
  end

  // R2
  cycle_code_chk: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |-> hit);
  // R4
  dead_code_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(code) >= NUM_EVT) |-> !hit);
endmodule

// File: rtl/pcb_counter_cell.sv
module pcb_counter_cell #(
  parameter int CTR_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CTR_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (clr) count <= CTR_W'(inc);
    else if (inc) count <= count + 1'b1;
  end

  // R6
  clear_value_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == CTR_W'($past(inc)));
  // R9
  step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc) |=> count == CTR_W'($past(count) + 1'b1));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/pcb_read_port.sv
module pcb_read_port #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [CTR_W-1:0] counts [NUM_CTR],
  output logic [CTR_W-1:0] rd_data,
  output logic             rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= counts[rd_idx];
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R5
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 64,
  parameter int NUM_EVT = pcb_pkg::EVT_COUNT,
  localparam int IDX_W  = $clog2(NUM_CTR),
  localparam int CODE_W = pcb_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CODE_W-1:0]  cfg_code,
  input  logic               cfg_clr_on_rd,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CTR_W-1:0]   rd_data,
  output logic               rd_valid
);
  ctr_cfg_t         wr_cfg;
  ctr_cfg_t         cfg    [NUM_CTR];
  logic [CTR_W-1:0] counts [NUM_CTR];
  logic             hit    [NUM_CTR];
  logic             clr    [NUM_CTR];

  assign wr_cfg = '{code: cfg_code, clr_on_rd: cfg_clr_on_rd};

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      logic wr_sel;
      assign wr_sel = cfg_wr && (cfg_idx == IDX_W'(g));
      assign clr[g] = rd_en && (rd_idx == IDX_W'(g)) && cfg[g].clr_on_rd;

      pcb_cfg_slot u_slot (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_sel),
        .wr_cfg (wr_cfg),
        .cfg    (cfg[g])
      );

      pcb_event_mux #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_mux (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt_pulse),
        .code (cfg[g].code),
        .hit  (hit[g])
      );

      pcb_counter_cell #(.CTR_W(CTR_W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .inc   (hit[g]),
        .clr   (clr[g]),
        .count (counts[g])
      );

      // R8
      cfg_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !clr[g]) |=> counts[g] == CTR_W'($past(counts[g]) + $past(hit[g])));
    end
  endgenerate

  pcb_read_port #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .counts   (counts),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: tb/perf_counter_bank_test.sv
`timescale 1ns/1ps
module perf_counter_bank_test;
  localparam int NC = 4;
  localparam int CW = 10;
  localparam int NE = 54;
  localparam int SW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [NE-1:0] evt_pulse = '0;
  logic          cfg_wr = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [SW-1:0] cfg_code = '0;
  logic          cfg_clr_on_rd = 1'b0;
  logic          rd_en = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_data;
  logic          rd_valid;

  perf_counter_bank #(.NUM_CTR(NC), .CTR_W(CW)) uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cfg_wr(cfg_wr),
    .cfg_idx(cfg_idx), .cfg_code(cfg_code), .cfg_clr_on_rd(cfg_clr_on_rd),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_cnt [NC];
  logic [SW-1:0] m_sel [NC];
  logic          m_cor [NC];
  logic [63:0]   lf = 64'h9E37_79B9_7F4A_7C15;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NE-1:0] next_evt();
    lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
    lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
    return lf[NE-1:0] ^ lf[63:64-NE];
  endfunction

  task automatic step(input logic r, input logic [NE-1:0] ev, input logic w,
                      input int widx, input logic [SW-1:0] wsel, input logic wcor,
                      input logic rd, input int ridx, input string tag);
    logic [CW-1:0] exp_rd;
    logic          h;
    @(negedge clk);
    rst = r; evt_pulse = ev; cfg_wr = w; cfg_idx = IW'(widx);
    cfg_code = wsel; cfg_clr_on_rd = wcor; rd_en = rd; rd_idx = IW'(ridx);
    exp_rd = m_cnt[ridx];
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin
      if (r) begin
        m_cnt[i] = '0; m_sel[i] = '0; m_cor[i] = 1'b0;
      end else begin
        if (m_sel[i] == 0)       h = 1'b1;
        else if (m_sel[i] < NE)  h = ev[m_sel[i]];
        else                     h = 1'b0;
        if (rd && ridx == i && m_cor[i]) m_cnt[i] = CW'(h);
        else                             m_cnt[i] = m_cnt[i] + CW'(h);
        if (w && widx == i) begin
          m_sel[i] = wsel; m_cor[i] = wcor;
        end
      end
    end
    #1;
    if (r) begin
      chk("R1 rd_valid", 64'(rd_valid), 64'd0);
      chk("R1 rd_data", 64'(rd_data), 64'd0);
    end else if (rd) begin
      chk({tag, " rd_valid"}, 64'(rd_valid), 64'd1);
      chk({tag, " rd_data"}, 64'(rd_data), 64'(exp_rd));
    end
  endtask

  task automatic idle(input logic [NE-1:0] ev);
    step(1'b0, ev, 1'b0, 0, '0, 1'b0, 1'b0, 0, "");
  endtask

  task automatic cfg(input int i, input logic [SW-1:0] c, input logic cor,
                     input logic [NE-1:0] ev);
    step(1'b0, ev, 1'b1, i, c, cor, 1'b0, 0, "");
  endtask

  task automatic rd(input int i, input logic [NE-1:0] ev, input string tag);
    step(1'b0, ev, 1'b0, 0, '0, 1'b0, 1'b1, i, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = '0; m_sel[i] = '0; m_cor[i] = 1'b0;
    end
    // R1: reset state
    repeat (3) step(1'b1, '1, 1'b0, 0, '0, 1'b0, 1'b0, 0, "");
    // R2: unconfigured counters count cycles, evt bit 0 ignored
    idle('0); idle('1); idle({NE{1'b0}} | 1);
    for (int i = 0; i < NC; i++) rd(i, next_evt(), "R2");
    // R7: plain reads do not clear
    for (int i = 0; i < NC; i++) rd(i, '0, "R7");

    // R3 R4 R2 R6: sweep every code over the four counters
    for (int code = 0; code < 64; code++) begin
      int c = code % NC;
      string tg;
      tg = (code == 0) ? "R2" : (code < NE) ? "R3" : "R4";
      cfg(c, SW'(code), 1'b1, next_evt());
      rd(c, next_evt(), "R6");
      for (int k = 0; k < 16; k++) idle(next_evt());
      rd(c, next_evt(), tg);
      rd(c, '0, "R6");
    end

    // R6: clearing read coinciding with the selected event
    cfg(1, 6'd5, 1'b1, '0);
    idle('1); idle('1);
    rd(1, {{(NE-6){1'b0}}, 6'b100000}, "R6");
    rd(1, '0, "R6");

    // R7: clear-on-read off keeps count across reads
    cfg(2, 6'd0, 1'b0, '0);
    rd(2, '0, "R7"); rd(2, '0, "R7"); rd(2, '0, "R7");

    // R8: reconfigure keeps count; old selection counts in the write cycle
    cfg(3, 6'd7, 1'b0, '0);
    for (int k = 0; k < 5; k++) idle('1);
    cfg(3, 6'd9, 1'b0, {{(NE-8){1'b0}}, 8'b1000_0000});
    idle({{(NE-10){1'b0}}, 10'b10_0000_0000});
    idle({{(NE-8){1'b0}}, 8'b1000_0000});
    rd(3, '0, "R8");

    // R10: clearing read on counter 1 leaves counter 2 alone
    cfg(1, 6'd0, 1'b1, '0);
    rd(1, '0, "R10");
    rd(2, '0, "R10");

    // R9: wrap with cycle code and clear-on-read off
    for (int i = 0; i < NC; i++) cfg(i, 6'd0, 1'b0, '0);
    for (int k = 0; k < 1100; k++) idle(next_evt());
    for (int i = 0; i < NC; i++) rd(i, '0, "R9");
    for (int k = 0; k < 1000; k++) idle('0);
    for (int i = 0; i < NC; i++) rd(i, '0, "R9");

    // R5: quiet cycle after reads
    idle('0);
    chk("R5 rd_valid idle", 64'(rd_valid), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule